// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a multi-channel event timer. The channel watches a free-running main counter that is shared by all channels and produces an interrupt request once that counter has reached a programmed comparator value. Software programs the channel through a 32-bit register port with four word addresses: configuration, a read-only capability word, and the low and high halves of the 64-bit comparator.

Two operating modes are available. In one-shot mode the channel fires once and then stays idle until it is re-armed. In periodic mode it reloads itself from a hidden period register. A 32-bit mode restricts the comparison to the low counter half. In that mode a one-shot channel also reports the moment the low half of the counter rolls over. A set-value control bit lets software place the comparator directly while the channel is periodic. The request is either a held level with a status flag that software clears, or a single-cycle pulse.

Top module: `evt_cmp_chan`

## Requirements
- R1: A comparator write loads the match value when the channel is one-shot, or when it is periodic with set-value set. In periodic mode a low-half write (word address 2) also loads the low half of the period. A high-half write (word address 3) loads the period's high half only when periodic with set-value clear, and loads the match value otherwise. Any comparator write to an enabled channel while the global enable is high re-arms the channel.
- R2: The most significant bit of a loaded period is forced to zero: bit 31 of a low-half write in 32-bit mode, and bit 63 of a high-half write.
- R3: The set-value bit (configuration bit 6) reads back as zero after any write to either comparator half.
- R4: A configuration write with the 32-bit bit (bit 8) set clears the upper 32 bits of both the comparator and the period.
- R5: In periodic mode with a nonzero period, a match raises one event and adds the period to the comparator. Further additions follow on later cycles, without further events, until the comparator is again ahead of the counter.
- R6: In 32-bit one-shot mode, a counter low half that steps from 0xFFFFFFFF to 0 raises an event and leaves the channel armed. A rollover and a match that fall in the same cycle produce a single event.
- R7: A 0-to-1 write of the enable bit (bit 2) arms the channel only while the global enable is high. A rise of the global enable arms an already enabled channel. A 1-to-0 enable write, or a fall of the global enable, disarms the channel and withdraws the request and status at the next edge.
- R8: After reset the comparator reads 0xFFFFFFFF in both halves and the period is zero. The configuration word (address 0) reads 0x30, where bit 4 advertises periodic support and bit 5 advertises 64-bit support. Address 1 reads zero and all register reads are returned one cycle after the address.
- R9: With the type bit (bit 1) set, an event sets the status output and holds the request high until status_ack. With the type bit clear, the status stays low and the request is high for exactly one cycle.
- R10: The counter counts as reached when the comparator minus the counter, taken at the active width, is zero or negative. A reached channel raises its event at the first clock edge after arming, and a one-shot channel raises it only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable shared by all channels |
| main_cnt | input | 64 | Shared main counter value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 config, 1 capability, 2 comparator low, 3 comparator high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| status_ack | input | 1 | Clears the level-mode status |
| irq | output | 1 | Interrupt request |
| irq_status | output | 1 | Level-mode pending status |
| irq_is_level | output | 1 | Type indication: 1 = level, 0 = edge |

## Verification
The counter rollover detector and the match comparator can both trigger in the same cycle in 32-bit one-shot mode. The bench provokes this by programming a comparator of zero and stepping the counter from a low half of 0xFFFFFFFF directly to a low half of zero. It then counts request pulses over several cycles and expects exactly one, with the channel staying quiet afterwards. It also drives the counter far past a periodic comparator, so that several reload additions run back to back, and checks that only one event appears while the comparator settles on the first value ahead of the counter.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CFG    = 2'd0,
    RA_CAPS   = 2'd1,
    RA_CMP_LO = 2'd2,
    RA_CMP_HI = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_LVL   = 1;
  localparam int unsigned BIT_EN    = 2;
  localparam int unsigned BIT_PER   = 3;
  localparam int unsigned BIT_CAPP  = 4;
  localparam int unsigned BIT_CAP64 = 5;
  localparam int unsigned BIT_SETV  = 6;
  localparam int unsigned BIT_M32   = 8;

  typedef struct packed {
    logic m32;
    logic setv;
    logic per;
    logic en;
    logic lvl;
  } chan_cfg_t;
endpackage

// File: rtl/evt_reach.sv
module evt_reach #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             m32,
  output logic             reached
);
  logic [CNT_W-1:0] d_full;
  logic             full_hit;

  assign d_full   = cmp - cnt;
  assign full_hit = d_full[CNT_W-1] || (d_full == '0);

  generate
    if (CNT_W > HALF_W) begin : g_dual
      logic [HALF_W-1:0] d_half;
      logic              half_hit;
      assign d_half   = cmp[HALF_W-1:0] - cnt[HALF_W-1:0];
      assign half_hit = d_half[HALF_W-1] || (d_half == '0);
      assign reached  = m32 ? half_hit : full_hit;
    end else begin : g_single
      logic unused_m32;
      assign unused_m32 = m32;
      assign reached    = full_hit;
    end
  endgenerate
endmodule

// File: rtl/evt_wrap_det.sv
module evt_wrap_det #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic              watch,
  output logic              wrap
);
  logic [HALF_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cnt_lo;
  end

  assign wrap = watch && (prev_q == {HALF_W{1'b1}}) && (cnt_lo == '0);

  AST_WRAP_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
    wrap |-> ($past(cnt_lo) == {HALF_W{1'b1}})); // R6
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic lvl,
  input  logic ack,
  input  logic kill,
  output logic irq,
  output logic sts
);
  logic sts_nx;
  logic irq_nx;

  always_comb begin
    if (kill)      sts_nx = 1'b0;
    else if (fire) sts_nx = lvl;
    else if (ack)  sts_nx = 1'b0;
    else           sts_nx = sts;
    irq_nx = kill ? 1'b0 : (lvl ? sts_nx : fire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 1'b0;
      irq <= 1'b0;
    end else begin
      sts <= sts_nx;
      irq <= irq_nx;
    end
  end

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fire && lvl && !kill) |=> (sts && irq)); // R9
  AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (fire && !lvl && !kill && !sts) |=> (irq && !sts)); // R9
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!irq && !sts)); // R7
endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic [CNT_W-1:0]  main_cnt,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              status_ack,
  output logic              irq,
  output logic              irq_status,
  output logic              irq_is_level
);
  localparam int unsigned HI_W = CNT_W - REG_W;

  chan_cfg_t        cfg_q, cfg_nx;
  logic [CNT_W-1:0] cmp_q, cmp_nx;
  logic [CNT_W-1:0] per_q, per_nx;
  logic             armed_q, armed_nx;
  logic             catch_q, catch_nx;
  logic             glb_q;
  logic [REG_W-1:0] rd_mux;

  logic wr_cfg, wr_lo, wr_hi;
  logic en_rise, en_fall, glb_rise, glb_fall;
  logic reached, wrap, fire, kill;
  logic per_zero, periodic_run;
  logic [CNT_W-1:0] cmp_sum, cmp_add;

  assign wr_cfg = reg_wr && (reg_addr == RA_CFG);
  assign wr_lo  = reg_wr && (reg_addr == RA_CMP_LO);
  assign wr_hi  = reg_wr && (reg_addr == RA_CMP_HI);

  assign en_rise  = wr_cfg &&  reg_wdata[BIT_EN] && !cfg_q.en;
  assign en_fall  = wr_cfg && !reg_wdata[BIT_EN] &&  cfg_q.en;
  assign glb_rise =  glb_en && !glb_q;
  assign glb_fall = !glb_en &&  glb_q;

  evt_reach #(.CNT_W(CNT_W), .HALF_W(REG_W)) u_reach (
    .cmp     (cmp_q),
    .cnt     (main_cnt),
    .m32     (cfg_q.m32),
    .reached (reached)
  );

  evt_wrap_det #(.HALF_W(REG_W)) u_wrap (
    .clk    (clk),
    .rst    (rst),
    .cnt_lo (main_cnt[REG_W-1:0]),
    .watch  (armed_q && cfg_q.m32 && !cfg_q.per),
    .wrap   (wrap)
  );

  assign per_zero     = cfg_q.m32 ? (per_q[REG_W-1:0] == '0) : (per_q == '0);
  assign periodic_run = cfg_q.per && !per_zero;
  assign cmp_sum      = cmp_q + per_q;
  assign cmp_add      = cfg_q.m32 ? {{HI_W{1'b0}}, cmp_sum[REG_W-1:0]} : cmp_sum;

  assign fire = armed_q && ((reached && !(periodic_run && catch_q)) || wrap);
  assign kill = en_fall || glb_fall;

  always_comb begin
    cfg_nx   = cfg_q;
    cmp_nx   = cmp_q;
    per_nx   = per_q;
    armed_nx = armed_q;
    catch_nx = 1'b0;

    if (armed_q && reached) begin
      if (periodic_run) begin
        cmp_nx   = cmp_add;
        catch_nx = 1'b1;
      end else begin
        armed_nx = 1'b0;
      end
    end

    if (glb_rise && cfg_q.en) armed_nx = 1'b1;
    if (glb_fall)             armed_nx = 1'b0;

    if (wr_cfg) begin
      cfg_nx.lvl  = reg_wdata[BIT_LVL];
      cfg_nx.en   = reg_wdata[BIT_EN];
      cfg_nx.per  = reg_wdata[BIT_PER];
      cfg_nx.setv = reg_wdata[BIT_SETV];
      cfg_nx.m32  = reg_wdata[BIT_M32];
      if (reg_wdata[BIT_M32]) begin
        cmp_nx[CNT_W-1:REG_W] = '0;
        per_nx[CNT_W-1:REG_W] = '0;
      end
      if (en_rise && glb_en) begin
        armed_nx = 1'b1;
        catch_nx = 1'b0;
      end
      if (en_fall) armed_nx = 1'b0;
    end

    if (wr_lo) begin
      if (!cfg_q.per || cfg_q.setv) cmp_nx[REG_W-1:0] = reg_wdata;
      if (cfg_q.per)
        per_nx[REG_W-1:0] = cfg_q.m32 ? {1'b0, reg_wdata[REG_W-2:0]} : reg_wdata;
    end

    if (wr_hi) begin
      if (!cfg_q.per || cfg_q.setv) cmp_nx[CNT_W-1:REG_W] = reg_wdata[HI_W-1:0];
      else                          per_nx[CNT_W-1:REG_W] = {1'b0, reg_wdata[HI_W-2:0]};
    end

    if (wr_lo || wr_hi) begin
      cfg_nx.setv = 1'b0;
      if (cfg_q.en && glb_en) begin
        armed_nx = 1'b1;
        catch_nx = 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(reg_addr))
      RA_CFG: begin
        rd_mux[BIT_LVL]   = cfg_q.lvl;
        rd_mux[BIT_EN]    = cfg_q.en;
        rd_mux[BIT_PER]   = cfg_q.per;
        rd_mux[BIT_CAPP]  = 1'b1;
        rd_mux[BIT_CAP64] = 1'b1;
        rd_mux[BIT_SETV]  = cfg_q.setv;
        rd_mux[BIT_M32]   = cfg_q.m32;
      end
      RA_CAPS:   rd_mux = '0;
      RA_CMP_LO: rd_mux = cmp_q[REG_W-1:0];
      RA_CMP_HI: rd_mux[HI_W-1:0] = cmp_q[CNT_W-1:REG_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cmp_q     <= '1;
      per_q     <= '0;
      armed_q   <= 1'b0;
      catch_q   <= 1'b0;
      glb_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      cfg_q     <= cfg_nx;
      cmp_q     <= cmp_nx;
      per_q     <= per_nx;
      armed_q   <= armed_nx;
      catch_q   <= catch_nx;
      glb_q     <= glb_en;
      reg_rdata <= rd_mux;
    end
  end

  evt_irq_out u_irq (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .lvl  (cfg_q.lvl),
    .ack  (status_ack),
    .kill (kill),
    .irq  (irq),
    .sts  (irq_status)
  );

  assign irq_is_level = cfg_q.lvl;

  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> ((cmp_q == '1) && (per_q == '0) && !armed_q)); // R8
  AST_PERIOD_CAP: assert property (@(posedge clk) disable iff (rst)
    !per_q[CNT_W-1]); // R2
  AST_SETV_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr[1]) |=> !cfg_q.setv); // R3
  AST_M32_TRUNC: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && reg_wdata[BIT_M32]) |=> ((cmp_q[CNT_W-1:REG_W] == '0) && (per_q[CNT_W-1:REG_W] == '0))); // R4
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (armed_q && reached && !cfg_q.per && !reg_wr && !glb_rise) |=> !armed_q); // R10
  AST_NO_ARM_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !glb_q && !armed_q) |=> !armed_q); // R7
endmodule

// File: tb/evt_cmp_chan_tb.sv
module evt_cmp_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        glb_en = 1'b0;
  logic [63:0] main_cnt = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        status_ack = 1'b0;
  logic        irq, irq_status, irq_is_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_cmp_chan dut_i (
    .clk(clk), .rst(rst), .glb_en(glb_en), .main_cnt(main_cnt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status_ack(status_ack), .irq(irq),
    .irq_status(irq_status), .irq_is_level(irq_is_level)
  );

  // {m32, comparator, counter, expected event}
  localparam logic [129:0] VECS [8] = '{
    {1'b0, 64'd100,                 64'd100,                 1'b1},
    {1'b0, 64'd101,                 64'd100,                 1'b0},
    {1'b0, 64'd50,                  64'd100,                 1'b1},
    {1'b0, 64'h8000_0000_0000_0064, 64'd100,                 1'b1},
    {1'b1, 64'h0000_0001_0000_0005, 64'd3,                   1'b0},
    {1'b1, 64'h0000_0000_0000_0002, 64'h0000_0005_0000_0003, 1'b1},
    {1'b1, 64'h0000_0000_9000_0000, 64'h0000_0000_1000_0000, 1'b1},
    {1'b0, 64'h0000_0000_9000_0000, 64'h0000_0000_1000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pulses(input int n, output int c, output logic first);
    c = 0;
    first = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) first = irq;
      c += int'(irq);
    end
  endtask

  always @(posedge clk) begin
    if (!done && $time > 64'd2_000_000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    logic f;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    rd(2'd0, v); chk("R8 cfg reset", v, 32'h30);
    rd(2'd1, v); chk("R8 caps word", v, 32'h0);
    rd(2'd2, v); chk("R8 cmp lo reset", v, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R8 cmp hi reset", v, 32'hFFFF_FFFF);
    chk("R8 irq reset", {irq, irq_status, irq_is_level}, 3'b000);

    // R10 table of reach decisions, one-shot edge mode
    glb_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 32'h0);
      main_cnt = VECS[i][64:1];
      wr(2'd2, VECS[i][96:65]);
      wr(2'd3, VECS[i][128:97]);
      wr(2'd0, VECS[i][129] ? 32'h104 : 32'h004);
      pulses(3, c, f);
      chk($sformatf("R10 vec%0d first-edge event", i), f, VECS[i][0]);
      chk($sformatf("R10 vec%0d one-shot count", i), c, VECS[i][0]);
    end

    // R9 level mode
    wr(2'd0, 32'h0);
    main_cnt = 64'd10;
    wr(2'd2, 32'd10);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h6);
    @(negedge clk);
    chk("R9 level request/status/type", {irq, irq_status, irq_is_level}, 3'b111);
    repeat (2) @(negedge clk);
    chk("R9 level held", {irq, irq_status}, 2'b11);
    status_ack = 1'b1;
    @(negedge clk);
    status_ack = 1'b0;
    chk("R9 ack clears", {irq, irq_status}, 2'b00);

    // R7 disarm withdraws request
    wr(2'd0, 32'h0);
    main_cnt = 64'd0;
    wr(2'd2, 32'd20);
    wr(2'd0, 32'h6);
    main_cnt = 64'd20;
    @(negedge clk);
    chk("R7 level fire before disable", irq, 1'b1);
    wr(2'd0, 32'h2);
    chk("R7 disable withdraws", {irq, irq_status}, 2'b00);

    // R7 global enable gating
    glb_en = 1'b0;
    wr(2'd0, 32'h0);
    main_cnt = 64'd5;
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h4);
    pulses(3, c, f);
    chk("R7 no arm with global off", c, 0);
    glb_en = 1'b1;
    pulses(4, c, f);
    chk("R7 global rise arms", c, 1);

    // R1 R3 R5 periodic
    wr(2'd0, 32'h0);
    main_cnt = 64'd0;
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h48);
    rd(2'd0, v); chk("R3 set-value visible", v, 32'h78);
    wr(2'd2, 32'd1000);
    rd(2'd0, v); chk("R3 set-value self clears", v, 32'h38);
    wr(2'd2, 32'd500);
    rd(2'd2, v); chk("R1 periodic write keeps match", v, 32'd1000);
    wr(2'd0, 32'h0C);
    main_cnt = 64'd1000;
    pulses(3, c, f);
    chk("R5 periodic single event", c, 1);
    rd(2'd2, v); chk("R1 R5 reload by written period", v, 32'd1500);
    main_cnt = 64'd2700;
    pulses(6, c, f);
    chk("R5 catch-up one event", c, 1);
    rd(2'd2, v); chk("R5 catch-up lands ahead", v, 32'd3000);

    // R2 period cap in 32-bit mode
    wr(2'd0, 32'h0);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h148);
    wr(2'd2, 32'h8000_0010);
    wr(2'd0, 32'h10C);
    main_cnt = 64'h8000_0010;
    pulses(3, c, f);
    chk("R2 capped-period event", c, 1);
    rd(2'd2, v); chk("R2 period top bit cleared", v, 32'h8000_0020);

    // R4 truncation
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h1234);
    wr(2'd3, 32'hABCD);
    rd(2'd3, v); chk("R4 hi before", v, 32'hABCD);
    wr(2'd0, 32'h100);
    rd(2'd3, v); chk("R4 hi truncated", v, 32'h0);
    rd(2'd2, v); chk("R4 lo kept", v, 32'h1234);

    // R6 rollover event then match
    wr(2'd0, 32'h0);
    main_cnt = 64'hFFFF_FFFE;
    wr(2'd2, 32'h10);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h104);
    pulses(2, c, f);
    chk("R6 no event before rollover", c, 0);
    main_cnt = 64'hFFFF_FFFF;
    pulses(1, c, f);
    main_cnt = 64'h1_0000_0000;
    pulses(3, c, f);
    chk("R6 rollover event", c, 1);
    main_cnt = 64'h1_0000_0010;
    pulses(3, c, f);
    chk("R6 match after rollover", c, 1);

    // R6 rollover and match in the same cycle
    wr(2'd0, 32'h0);
    main_cnt = 64'h1_FFFF_FFFF;
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h104);
    pulses(2, c, f);
    chk("R6 armed quiet", c, 0);
    main_cnt = 64'h2_0000_0000;
    pulses(5, c, f);
    chk("R6 coincident single event", c, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule